// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block keeps a small ring of receive descriptors in flops and moves arriving frames into host buffers under the control of those descriptors. Each ring entry has three fields: a 16-bit status word, a 16-bit length word and a buffer index. Software fills the entries through a simple register port. It marks each entry as free for the engine by setting its empty bit, and sets the wrap bit on the last entry. It then writes the poll register to start the engine. Bytes come in on a stream with start-of-frame, end-of-frame and error flags. The engine passes each accepted byte to a buffer write port, tagged with the entry's buffer index and the byte offset. When the frame ends, it writes the length and status into the entry, which returns the entry to software, and moves on to the next entry.

The control is a four-state machine. **IDLE** is entered at reset and left for **READY** on a poll write. **READY** waits for a start byte. If the current entry is not empty it moves to **PARKED**. A start byte with no end flag moves it to **FILL**, and a single-byte frame closes at once. **FILL** stores bytes and returns to **READY** on the end byte, closing the entry in that same cycle. **PARKED** drops every frame and flags an overrun for each one. A poll write returns it to **READY** at the same ring index.

Every effect of a byte seen at a clock edge is visible after that edge: the buffer write, the updated entry, the advanced index and the frame-done pulse.

Top module: `rxr_ring_engine`

## Requirements
- R1: The engine accepts a frame only into a current entry whose empty bit (status bit 15) is set, and only from a byte marked start-of-frame; bytes without a start flag while READY are ignored.
- R2: On the end byte, the entry's length word becomes the number of bytes delivered for the frame, counting the 4 trailing check bytes. Its status becomes: bit 15 cleared, bit 11 set, wrap bit 13 kept as it was, bit 0 set if any byte of the frame carried the error flag, bit 5 set if the frame was truncated, and every other bit 0.
- R3: After closing an entry the ring index steps by one. It returns to 0 instead when the closed entry had its wrap bit set or was the last entry.
- R4: After reset the ring index is 0, overrun, parked and frame_done are low, and every frame is ignored until a poll write. A poll write is a write to field 3 with data bit 24 set; a write to field 3 with bit 24 clear has no effect.
- R5: The host address is {field[1:0], entry}. Field 0 is status, 1 is length, 2 is buffer index and 3 is poll. Reads are combinational and zero-extended to 32 bits, and field 3 reads as 0.
- R6: When the current entry is not empty the engine parks. Each start byte while parked sets a sticky overrun flag and writes no bytes. A poll write clears overrun and resumes at the same index.
- R7: frame_done is high for exactly one cycle after each closed entry.
- R8: Bytes beyond MAX_FRAME are not written. The length word then records MAX_FRAME and status bit 5 is set.
- R9: Each accepted byte appears on the buffer port the cycle after it is presented. buf_we is high, buf_idx holds the entry's buffer index, buf_off counts from 0 within the frame, and buf_data holds the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | $clog2(N_DESC)+2 | {field, entry} |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational) |
| rx_valid | input | 1 | Stream byte valid |
| rx_data | input | 8 | Stream byte |
| rx_sof | input | 1 | First byte of frame |
| rx_eof | input | 1 | Last byte of frame |
| rx_err | input | 1 | Byte carries a receive error |
| buf_we | output | 1 | Buffer byte write enable |
| buf_idx | output | BIDX_W | Buffer index of the current entry |
| buf_off | output | $clog2(BUF_BYTES+1) | Byte offset within the buffer |
| buf_data | output | 8 | Byte to write |
| frame_done | output | 1 | One-cycle pulse per closed entry |
| ring_idx | output | $clog2(N_DESC) | Current ring entry |
| overrun | output | 1 | Sticky: frame dropped while parked |
| parked | output | 1 | Engine is in PARKED |

## Verification
The bench builds the engine with N_DESC=4, MAX_FRAME=20, BUF_BYTES=24 and BIDX_W=8. With four entries, one pass around the ring reaches the wrap entry after only three frames, and wrapping back onto an entry already returned to software forces the park and overrun path. A 20-byte frame limit lets a 25-byte frame exercise truncation in a few dozen cycles rather than over 1500.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READY  = 2'd1,
        ST_FILL   = 2'd2,
        ST_PARKED = 2'd3
    } rxr_state_e;

    typedef enum logic [1:0] {
        FLD_STATUS = 2'd0,
        FLD_LEN    = 2'd1,
        FLD_BUF    = 2'd2,
        FLD_POLL   = 2'd3
    } rxr_field_e;

    localparam int EMPTY_BIT   = 15;
    localparam int WRAP_BIT    = 13;
    localparam int LAST_BIT    = 11;
    localparam int ERR_FRM_BIT = 0;
    localparam int ERR_LEN_BIT = 5;
    localparam int POLL_BIT    = 24;

endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
    parameter int N_DESC = 8,
    localparam int IDX_W = $clog2(N_DESC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             wrap_flag,
    output logic [IDX_W-1:0] idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_DESC - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (advance) begin
            if (wrap_flag || idx == LAST_IDX) begin
                idx <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        advance && wrap_flag |=> idx == '0); // R3

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        advance && !wrap_flag && idx != LAST_IDX |=> idx == $past(idx) + 1'b1); // R3

    AST_HOLD_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(idx)); // R3

endmodule

// File: rtl/rxr_desc_table.sv
module rxr_desc_table
    import rxr_pkg::*;
#(
    parameter int N_DESC = 8,
    parameter int BIDX_W = 8,
    localparam int IDX_W = $clog2(N_DESC),
    localparam int AW    = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [AW-1:0]     host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              poll_req,
    input  logic [IDX_W-1:0]  cur_idx,
    output logic [15:0]       cur_status,
    output logic [BIDX_W-1:0] cur_bidx,
    input  logic              cl_en,
    input  logic [15:0]       cl_status,
    input  logic [15:0]       cl_len
);

    logic [15:0]       st_mem  [N_DESC];
    logic [15:0]       len_mem [N_DESC];
    logic [BIDX_W-1:0] bi_mem  [N_DESC];

    rxr_field_e       h_field;
    logic [IDX_W-1:0] h_entry;
    logic             h_in_range;
    logic             unused_wdata;

    assign h_field      = rxr_field_e'(host_addr[AW-1:IDX_W]);
    assign h_entry      = host_addr[IDX_W-1:0];
    assign h_in_range   = int'(h_entry) < N_DESC;
    assign unused_wdata = ^host_wdata;

    assign poll_req   = host_wr && (h_field == FLD_POLL) && host_wdata[POLL_BIT];
    assign cur_status = st_mem[cur_idx];
    assign cur_bidx   = bi_mem[cur_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < N_DESC; e++) begin
                st_mem[e]  <= '0;
                len_mem[e] <= '0;
                bi_mem[e]  <= '0;
            end
        end else begin
            for (int e = 0; e < N_DESC; e++) begin
                if (cl_en && cur_idx == IDX_W'(e)) begin
                    st_mem[e]  <= cl_status;
                    len_mem[e] <= cl_len;
                end else if (host_wr && h_entry == IDX_W'(e)) begin
                    if (h_field == FLD_STATUS) st_mem[e]  <= host_wdata[15:0];
                    if (h_field == FLD_LEN)    len_mem[e] <= host_wdata[15:0];
                end
                if (host_wr && h_entry == IDX_W'(e) && h_field == FLD_BUF) begin
                    bi_mem[e] <= host_wdata[BIDX_W-1:0];
                end
            end
        end
    end

    always_comb begin
        host_rdata = '0;
        if (h_in_range) begin
            unique case (h_field)
                FLD_STATUS: host_rdata = {16'd0, st_mem[h_entry]};
                FLD_LEN:    host_rdata = {16'd0, len_mem[h_entry]};
                FLD_BUF:    host_rdata = 32'(bi_mem[h_entry]);
                FLD_POLL:   host_rdata = '0;
            endcase
        end
    end

    AST_CLOSE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        cl_en |=> st_mem[$past(cur_idx)][EMPTY_BIT] == 1'b0); // R2

    AST_CLOSE_MARKS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        cl_en |=> st_mem[$past(cur_idx)][LAST_BIT] == 1'b1); // R2

endmodule

// File: rtl/rxr_fill_ctrl.sv
module rxr_fill_ctrl
    import rxr_pkg::*;
#(
    parameter int MAX_FRAME = 1518,
    parameter int CNT_W     = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             poll,
    input  logic             cur_empty,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic             rx_eof,
    input  logic             rx_err,
    output logic             store,
    output logic [CNT_W-1:0] store_off,
    output logic             close,
    output logic [15:0]      close_len,
    output logic [5:0]       close_err,
    output logic             overrun,
    output rxr_state_e       state
);

    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_FRAME);

    rxr_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             err_q, err_d;
    logic             trunc_q, trunc_d;
    logic             set_ovr;

    assign state = st_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d      = st_q;
        store     = 1'b0;
        store_off = cnt_q;
        close     = 1'b0;
        set_ovr   = 1'b0;
        cnt_d     = cnt_q;
        err_d     = err_q;
        trunc_d   = trunc_q;
        unique case (st_q)
            ST_IDLE: begin
                if (poll) st_d = ST_READY;
            end
            ST_READY: begin
                if (!cur_empty) begin
                    st_d    = ST_PARKED;
                    set_ovr = rx_valid && rx_sof;
                end else if (rx_valid && rx_sof) begin
                    store     = 1'b1;
                    store_off = '0;
                    cnt_d     = CNT_W'(1);
                    err_d     = rx_err;
                    trunc_d   = 1'b0;
                    if (rx_eof) close = 1'b1;
                    else        st_d  = ST_FILL;
                end
            end
            ST_FILL: begin
                if (rx_valid) begin
                    if (cnt_q < MAX_CNT) begin
                        store = 1'b1;
                        cnt_d = cnt_q + 1'b1;
                    end else begin
                        trunc_d = 1'b1;
                    end
                    err_d = err_q | rx_err;
                    if (rx_eof) begin
                        close = 1'b1;
                        st_d  = ST_READY;
                    end
                end
            end
            ST_PARKED: begin
                if (poll) st_d = ST_READY;
                else      set_ovr = rx_valid && rx_sof;
            end
        endcase
    end

    assign close_len = 16'(cnt_d);
    always_comb begin
        close_err              = '0;
        close_err[ERR_FRM_BIT] = err_d;
        close_err[ERR_LEN_BIT] = trunc_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            err_q   <= 1'b0;
            trunc_q <= 1'b0;
            overrun <= 1'b0;
        end else begin
            cnt_q   <= cnt_d;
            err_q   <= err_d;
            trunc_q <= trunc_d;
            if (poll)         overrun <= 1'b0;
            else if (set_ovr) overrun <= 1'b1;
        end
    end

    AST_STORE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        store |-> store_off < MAX_CNT); // R8

    AST_OVR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        poll |=> !overrun); // R6

    AST_IDLE_UNTIL_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_IDLE && !poll |=> st_q == ST_IDLE); // R4

    AST_PARKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_PARKED |-> !store && !close); // R6

endmodule

// File: rtl/rxr_ring_engine.sv
module rxr_ring_engine
    import rxr_pkg::*;
#(
    parameter int N_DESC    = 8,
    parameter int BIDX_W    = 8,
    parameter int BUF_BYTES = 1520,
    parameter int MAX_FRAME = 1518
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             host_wr,
    input  logic [$clog2(N_DESC)+1:0]        host_addr,
    input  logic [31:0]                      host_wdata,
    output logic [31:0]                      host_rdata,
    input  logic                             rx_valid,
    input  logic [7:0]                       rx_data,
    input  logic                             rx_sof,
    input  logic                             rx_eof,
    input  logic                             rx_err,
    output logic                             buf_we,
    output logic [BIDX_W-1:0]                buf_idx,
    output logic [$clog2(BUF_BYTES+1)-1:0]   buf_off,
    output logic [7:0]                       buf_data,
    output logic                             frame_done,
    output logic [$clog2(N_DESC)-1:0]        ring_idx,
    output logic                             overrun,
    output logic                             parked
);

    localparam int IDX_W = $clog2(N_DESC);
    localparam int CNT_W = $clog2(BUF_BYTES + 1);

    logic [IDX_W-1:0]  cur_idx;
    logic [15:0]       cur_status;
    logic [BIDX_W-1:0] cur_bidx;
    logic              poll_req;
    logic              store;
    logic [CNT_W-1:0]  store_off;
    logic              close;
    logic [15:0]       close_len;
    logic [5:0]        close_err;
    logic [15:0]       cl_status;
    rxr_state_e        state;

    initial begin
        if (MAX_FRAME > BUF_BYTES || N_DESC < 2) $error("rxr_ring_engine: bad parameters");
    end

    always_comb begin
        cl_status           = {10'd0, close_err};
        cl_status[WRAP_BIT] = cur_status[WRAP_BIT];
        cl_status[LAST_BIT] = 1'b1;
    end

    rxr_desc_table #(.N_DESC(N_DESC), .BIDX_W(BIDX_W)) i_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .poll_req   (poll_req),
        .cur_idx    (cur_idx),
        .cur_status (cur_status),
        .cur_bidx   (cur_bidx),
        .cl_en      (close),
        .cl_status  (cl_status),
        .cl_len     (close_len)
    );

    rxr_fill_ctrl #(.MAX_FRAME(MAX_FRAME), .CNT_W(CNT_W)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .poll      (poll_req),
        .cur_empty (cur_status[EMPTY_BIT]),
        .rx_valid  (rx_valid),
        .rx_sof    (rx_sof),
        .rx_eof    (rx_eof),
        .rx_err    (rx_err),
        .store     (store),
        .store_off (store_off),
        .close     (close),
        .close_len (close_len),
        .close_err (close_err),
        .overrun   (overrun),
        .state     (state)
    );

    rxr_ring_ptr #(.N_DESC(N_DESC)) i_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (close),
        .wrap_flag (cur_status[WRAP_BIT]),
        .idx       (cur_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_we     <= 1'b0;
            buf_idx    <= '0;
            buf_off    <= '0;
            buf_data   <= '0;
            frame_done <= 1'b0;
        end else begin
            buf_we     <= store;
            buf_idx    <= cur_bidx;
            buf_off    <= store_off;
            buf_data   <= rx_data;
            frame_done <= close;
        end
    end

    assign ring_idx = cur_idx;
    assign parked   = (state == ST_PARKED);

    AST_ACCEPT_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        store |-> cur_status[EMPTY_BIT]); // R1

    AST_DONE_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        close |=> frame_done && ring_idx != $past(ring_idx)); // R7

endmodule

// File: tb/test_rxr_ring_engine.sv
module test_rxr_ring_engine;

    localparam int CLK_PERIOD = 10;
    localparam int N_DESC     = 4;
    localparam int BIDX_W     = 8;
    localparam int BUF_BYTES  = 24;
    localparam int MAX_FRAME  = 20;
    localparam int AW         = $clog2(N_DESC) + 2;
    localparam int OW         = $clog2(BUF_BYTES + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_wr = 1'b0;
    logic [AW-1:0]     host_addr = '0;
    logic [31:0]       host_wdata = '0;
    logic [31:0]       host_rdata;
    logic              rx_valid = 1'b0;
    logic [7:0]        rx_data = '0;
    logic              rx_sof = 1'b0;
    logic              rx_eof = 1'b0;
    logic              rx_err = 1'b0;
    logic              buf_we;
    logic [BIDX_W-1:0] buf_idx;
    logic [OW-1:0]     buf_off;
    logic [7:0]        buf_data;
    logic              frame_done;
    logic [1:0]        ring_idx;
    logic              overrun;
    logic              parked;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxr_ring_engine #(.N_DESC(N_DESC), .BIDX_W(BIDX_W), .BUF_BYTES(BUF_BYTES),
                      .MAX_FRAME(MAX_FRAME)) i_rxr_ring_engine (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err),
        .buf_we(buf_we), .buf_idx(buf_idx), .buf_off(buf_off), .buf_data(buf_data),
        .frame_done(frame_done), .ring_idx(ring_idx), .overrun(overrun), .parked(parked)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input int field, input int entry, input logic [31:0] data);
        @(negedge clk);
        host_wr    = 1'b1;
        host_addr  = AW'((field << 2) | entry);
        host_wdata = data;
        @(posedge clk);
        #1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input int field, input int entry, output logic [31:0] data);
        @(negedge clk);
        host_addr = AW'((field << 2) | entry);
        #1;
        data = host_rdata;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    // n bytes; err_at = -1 for none; n_store = bytes expected on buffer port
    task automatic send_frame(input string req, input int n, input int err_at,
                              input logic [7:0] base, input int n_store,
                              input logic [7:0] exp_bidx, input logic exp_done);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = base + 8'(i);
            rx_sof   = (i == 0);
            rx_eof   = (i == n - 1);
            rx_err   = (i == err_at);
            @(posedge clk);
            #1;
            if (i < n_store) begin
                chk({req, " buf_we"}, 32'(buf_we), 32'd1);
                chk({req, " buf_off"}, 32'(buf_off), 32'(i));
                chk({req, " buf_data"}, 32'(buf_data), 32'(base + 8'(i)));
                chk({req, " buf_idx"}, 32'(buf_idx), 32'(exp_bidx));
            end else begin
                chk({req, " no write"}, 32'(buf_we), 32'd0);
            end
            if (i < n - 1) chk({req, " no early done"}, 32'(frame_done), 32'd0);
        end
        chk({req, " frame_done R7"}, 32'(frame_done), 32'(exp_done));
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
        @(posedge clk);
        #1;
        chk({req, " frame_done one cycle R7"}, 32'(frame_done), 32'd0);
    endtask

    task automatic check_entry(input string req, input int e,
                               input logic [15:0] exp_st, input logic [15:0] exp_len);
        logic [31:0] v;
        host_read(0, e, v);
        chk({req, " status"}, v, 32'(exp_st));
        host_read(1, e, v);
        chk({req, " length"}, v, 32'(exp_len));
    endtask

    task automatic t_reset_and_setup();
        logic [31:0] v;
        chk("R4 ring_idx", 32'(ring_idx), 0);
        chk("R4 overrun", 32'(overrun), 0);
        chk("R4 parked", 32'(parked), 0);
        chk("R4 frame_done", 32'(frame_done), 0);
        send_frame("R4 before poll", 3, -1, 8'h40, 0, 8'h00, 1'b0);
        for (int e = 0; e < N_DESC; e++) begin
            host_write(0, e, (e == N_DESC - 1) ? 32'h0000_A000 : 32'h0000_8000);
            host_write(2, e, 32'(16 + e));
        end
        host_read(2, 2, v);
        chk("R5 buffer index readback", v, 32'd18);
        host_read(0, 3, v);
        chk("R5 status readback", v, 32'h0000_A000);
        host_write(3, 0, 32'h0000_0001);
        host_read(3, 0, v);
        chk("R5 poll field reads zero", v, 0);
        send_frame("R4 poll without bit 24", 3, -1, 8'h50, 0, 8'h00, 1'b0);
        chk("R4 still idle idx", 32'(ring_idx), 0);
        host_write(3, 0, 32'h0100_0000);
    endtask

    task automatic t_no_sof_ignored();
        @(negedge clk);
        rx_valid = 1'b1; rx_data = 8'h77;
        @(posedge clk);
        #1;
        chk("R1 byte without sof ignored", 32'(buf_we), 0);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic t_basic();
        send_frame("R9 basic frame", 8, -1, 8'h10, 8, 8'd16, 1'b1);
        chk("R3 idx after first close", 32'(ring_idx), 1);
        check_entry("R2 basic", 0, 16'h0800, 16'd8);
    endtask

    task automatic t_error();
        send_frame("R2 error frame", 5, 2, 8'h20, 5, 8'd17, 1'b1);
        check_entry("R2 error flag", 1, 16'h0801, 16'd5);
        chk("R3 idx after second", 32'(ring_idx), 2);
    endtask

    task automatic t_trunc();
        send_frame("R8 long frame", 25, -1, 8'h80, MAX_FRAME, 8'd18, 1'b1);
        check_entry("R8 truncated", 2, 16'h0820, 16'(MAX_FRAME));
    endtask

    task automatic t_wrap();
        send_frame("R3 wrap frame", 6, -1, 8'hC0, 6, 8'd19, 1'b1);
        check_entry("R2 wrap kept", 3, 16'h2800, 16'd6);
        chk("R3 idx wraps to 0", 32'(ring_idx), 0);
    endtask

    task automatic t_park();
        idle_cycles(2);
        chk("R6 parked on owned entry", 32'(parked), 1);
        chk("R6 no overrun yet", 32'(overrun), 0);
        send_frame("R6 frame while parked", 3, -1, 8'hE0, 0, 8'h00, 1'b0);
        chk("R6 overrun set", 32'(overrun), 1);
        check_entry("R6 entry untouched", 0, 16'h0800, 16'd8);
        host_write(0, 0, 32'h0000_8000);
        chk("R6 overrun sticky", 32'(overrun), 1);
        host_write(3, 0, 32'h0100_0000);
        chk("R6 overrun cleared", 32'(overrun), 0);
        chk("R6 resumed", 32'(parked), 0);
        chk("R6 same index", 32'(ring_idx), 0);
        send_frame("R1 one-byte frame", 1, -1, 8'h5A, 1, 8'd16, 1'b1);
        check_entry("R1 one-byte", 0, 16'h0800, 16'd1);
        chk("R3 idx after rearm", 32'(ring_idx), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle_cycles(3);
        @(negedge clk);
        rst_n = 1'b1;
        idle_cycles(1);
        t_reset_and_setup();
        t_no_sof_ignored();
        t_basic();
        t_error();
        t_trunc();
        t_wrap();
        t_park();
        idle_cycles(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule